// File: doc/BRIEF.md
# Shared-Port Direction Arbiter with Safety Gating

This block converts input/output direction requests from two client devices into the control lines of shared LVDS transceivers and voltage-level translators. Client A owns a set of cables outright; a set of shared connectors is reachable from both client A and an optional client B. Each cable or connector has one transceiver direction line. Each translator set has a direction line and an active-low output enable.

Every request, configured flag and the fitted flag passes through a multi-flop synchronizer before it is used. A port stays in a forced safe state until the clients it depends on report that they are configured. In that state the transceiver drives outward, the translators point outward and the translator outputs are disabled. A client B that is not fitted is overridden completely. On a shared connector driven outward, only one translator set is ever enabled, and client A wins a contention. Every direction change follows a break-before-make sequence: the enables turn off first, then the direction moves, then the enables turn back on. A packed status word shows the synchronized requests and every control line. An active-low running-OK output goes low only when all needed clients are configured.

Top module: `port_dir_arbiter`

## Requirements
- R1: A configured cable whose request is high (input) settles to transceiver and translator direction 0 with the output enable low. A request that is low (output) settles to direction 1 with the enable low.
- R2: During and after reset, and while client A is not configured, every cable control line is high (direction 1, output enable high). At reset every shared-connector line and running-OK are also high.
- R3: The transceiver direction of each port equals the direction line of each of its fitted translator sets.
- R4: While the fitted flag is high (client B absent), client B's requests have no effect on any output, and its translator direction and output enable are both high.
- R5: On a shared connector driven outward (direction 1), at most one translator enable is low. When both clients request output, client A's set is enabled and client B's is disabled with direction 1. When only client B requests output, client B's set is enabled and client A's is disabled with direction 1.
- R6: A shared connector holds direction 1 with both enables high until client A is configured and client B is configured or absent.
- R7: When a direction line changes, the output enables of its translator sets are high on the edge of the change and on the edge before it. The enables come back no earlier than the edge after the change.
- R8: The running-OK output goes low three clock edges after client A is configured while client B is configured or absent. It is high in every other case.
- R9: The status word gives cable i 4 bits at offset 4*i: bit0 synchronized request, bit1 transceiver direction, bit2 translator direction, bit3 output enable. Shared connector j takes 7 bits at offset 4*NUM_CABLES+7*j: bit0 A request, bit1 B request, bit2 transceiver direction, bit3 A direction, bit4 A enable, bit5 B direction, bit6 B enable.
- R10: A request change has no effect on any output before the third rising edge after it is applied.
- R11: On a configured shared connector that both fitted clients request as input, the direction is 0 and every fitted translator set is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a_i | input | 1 | Client A configured |
| cfg_b_i | input | 1 | Client B configured |
| b_fitted_n_i | input | 1 | Low when client B is fitted |
| cab_req_in_i | input | NUM_CABLES | Client A cable requests, high = input |
| shr_req_in_a_i | input | NUM_SHARED | Client A shared-connector requests, high = input |
| shr_req_in_b_i | input | NUM_SHARED | Client B shared-connector requests, high = input |
| cab_xcvr_dir_o | output | NUM_CABLES | Cable transceiver direction, 1 = driver on |
| cab_xlat_dir_o | output | NUM_CABLES | Cable translator direction, 1 = outward |
| cab_xlat_oe_n_o | output | NUM_CABLES | Cable translator output enable, active low |
| shr_xcvr_dir_o | output | NUM_SHARED | Shared transceiver direction |
| shr_a_dir_o | output | NUM_SHARED | Client A translator direction |
| shr_a_oe_n_o | output | NUM_SHARED | Client A translator enable, active low |
| shr_b_dir_o | output | NUM_SHARED | Client B translator direction |
| shr_b_oe_n_o | output | NUM_SHARED | Client B translator enable, active low |
| status_o | output | 4*NUM_CABLES+7*NUM_SHARED | Packed status word |
| run_ok_n_o | output | 1 | Running OK, active low |

## Verification
An input reaches the synchronized copy after two edges. Running-OK moves on the third edge. A direction change takes the enables off on the third edge, moves the direction on the fourth and restores the enables on the fifth. A handover between clients on an outward connector finishes by the fifth edge. The bench checks these edges one at a time for one cable and for running-OK, sampling on falling edges. For every other pattern, directed or random, it waits eight cycles so each sequence has finished, then compares the settled outputs with values its own model computes.

// File: rtl/pda_pkg.sv
package pda_pkg;
   // cable status field positions
   localparam int CAB_F_REQ   = 0;
   localparam int CAB_F_XCVR  = 1;
   localparam int CAB_F_XDIR  = 2;
   localparam int CAB_F_OEN   = 3;
   localparam int CAB_FIELDS  = 4;
   // shared connector status field positions
   localparam int SHR_F_REQA  = 0;
   localparam int SHR_F_REQB  = 1;
   localparam int SHR_F_XCVR  = 2;
   localparam int SHR_F_ADIR  = 3;
   localparam int SHR_F_AOEN  = 4;
   localparam int SHR_F_BDIR  = 5;
   localparam int SHR_F_BOEN  = 6;
   localparam int SHR_FIELDS  = 7;

   function automatic int stat_width(input int n_cab, input int n_shr);
      return n_cab * CAB_FIELDS + n_shr * SHR_FIELDS;
   endfunction
endpackage

// File: rtl/pda_sync.sv
module pda_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pda_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pda_port_seq.sv
module pda_port_seq #(
   parameter int SETS = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            want_dir,
   input  logic [SETS-1:0] want_en,
   input  logic [SETS-1:0] fitted,
   output logic            dir_o,
   output logic [SETS-1:0] set_dir_o,
   output logic [SETS-1:0] oe_n_o
);
   if (SETS < 1 || SETS > 8) begin : g_bad_sets
      $error("pda_port_seq: SETS out of range");
   end

   logic            dir_q;
   logic [SETS-1:0] oe_q;
   logic [SETS-1:0] en_eff;
   logic [SETS-1:0] others_on;
   logic [SETS-1:0] oe_nxt;

   assign en_eff = ~oe_q & fitted;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      assign others_on[s] = |(en_eff & ~(SETS'(1) << s));
      // enable only when pointed inward, or no other set drives outward
      assign oe_nxt[s] = ~(want_en[s] & fitted[s] &
                           (~dir_q | ~others_on[s] | ~oe_q[s]));
      assign set_dir_o[s] = dir_q | ~fitted[s];
      assign oe_n_o[s]    = oe_q[s] | ~fitted[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b1;
         oe_q  <= '1;
      end else if (dir_q != want_dir) begin
         oe_q <= '1;
         if (en_eff == '0) dir_q <= want_dir;
      end else begin
         oe_q <= oe_nxt;
      end
   end

   assign dir_o = dir_q;
endmodule

// File: rtl/port_dir_arbiter.sv
module port_dir_arbiter
   import pda_pkg::*;
#(
   parameter int NUM_CABLES  = 3,
   parameter int NUM_SHARED  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int STAT_W = NUM_CABLES * CAB_FIELDS + NUM_SHARED * SHR_FIELDS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_a_i,
   input  logic                  cfg_b_i,
   input  logic                  b_fitted_n_i,
   input  logic [NUM_CABLES-1:0] cab_req_in_i,
   input  logic [NUM_SHARED-1:0] shr_req_in_a_i,
   input  logic [NUM_SHARED-1:0] shr_req_in_b_i,
   output logic [NUM_CABLES-1:0] cab_xcvr_dir_o,
   output logic [NUM_CABLES-1:0] cab_xlat_dir_o,
   output logic [NUM_CABLES-1:0] cab_xlat_oe_n_o,
   output logic [NUM_SHARED-1:0] shr_xcvr_dir_o,
   output logic [NUM_SHARED-1:0] shr_a_dir_o,
   output logic [NUM_SHARED-1:0] shr_a_oe_n_o,
   output logic [NUM_SHARED-1:0] shr_b_dir_o,
   output logic [NUM_SHARED-1:0] shr_b_oe_n_o,
   output logic [STAT_W-1:0]     status_o,
   output logic                  run_ok_n_o
);
   if (NUM_CABLES < 1) begin : g_bad_cab
      $error("port_dir_arbiter: NUM_CABLES must be positive");
   end
   if (NUM_SHARED < 1) begin : g_bad_shr
      $error("port_dir_arbiter: NUM_SHARED must be positive");
   end
   if (STAT_W != stat_width(NUM_CABLES, NUM_SHARED)) begin : g_bad_stat
      $error("port_dir_arbiter: status width mismatch");
   end

   localparam int SW = NUM_CABLES + 2 * NUM_SHARED + 3;
   localparam logic [SW-1:0] SYNC_RST =
      {1'b1, 1'b0, 1'b0, {NUM_SHARED{1'b1}}, {NUM_SHARED{1'b1}}, {NUM_CABLES{1'b1}}};

   logic [SW-1:0]         sync_q;
   logic [NUM_CABLES-1:0] cab_req_s;
   logic [NUM_SHARED-1:0] req_a_s, req_b_s;
   logic                  cfg_a_s, cfg_b_s, b_absent_s, both_ok;

   pda_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({b_fitted_n_i, cfg_b_i, cfg_a_i, shr_req_in_b_i, shr_req_in_a_i, cab_req_in_i}),
      .q_o   (sync_q)
   );

   assign {b_absent_s, cfg_b_s, cfg_a_s, req_b_s, req_a_s, cab_req_s} = sync_q;
   assign both_ok = cfg_a_s & (b_absent_s | cfg_b_s);

   // cables: single owner, single translator set
   for (genvar i = 0; i < NUM_CABLES; i++) begin : g_cab
      pda_port_seq #(.SETS(1)) u_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .want_dir  (~cfg_a_s | ~cab_req_s[i]),
         .want_en   (cfg_a_s),
         .fitted    (1'b1),
         .dir_o     (cab_xcvr_dir_o[i]),
         .set_dir_o (cab_xlat_dir_o[i +: 1]),
         .oe_n_o    (cab_xlat_oe_n_o[i +: 1])
      );
   end

   // shared connectors: client A has priority when driving outward
   logic [NUM_SHARED-1:0] want_shr, en_a, en_b;

   always_comb begin
      for (int j = 0; j < NUM_SHARED; j++) begin
         logic a_out, b_out, drv;
         a_out       = ~req_a_s[j];
         b_out       = ~b_absent_s & ~req_b_s[j];
         drv         = a_out | b_out;
         want_shr[j] = ~both_ok | drv;
         en_a[j]     = both_ok & (~drv | a_out);
         en_b[j]     = both_ok & ~b_absent_s & (~drv | (b_out & ~a_out));
      end
   end

   for (genvar j = 0; j < NUM_SHARED; j++) begin : g_shr
      pda_port_seq #(.SETS(2)) u_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .want_dir  (want_shr[j]),
         .want_en   ({en_b[j], en_a[j]}),
         .fitted    ({~b_absent_s, 1'b1}),
         .dir_o     (shr_xcvr_dir_o[j]),
         .set_dir_o ({shr_b_dir_o[j], shr_a_dir_o[j]}),
         .oe_n_o    ({shr_b_oe_n_o[j], shr_a_oe_n_o[j]})
      );
   end

   always_comb begin
      status_o = '0;
      for (int i = 0; i < NUM_CABLES; i++) begin
         status_o[i*CAB_FIELDS + CAB_F_REQ]  = cab_req_s[i];
         status_o[i*CAB_FIELDS + CAB_F_XCVR] = cab_xcvr_dir_o[i];
         status_o[i*CAB_FIELDS + CAB_F_XDIR] = cab_xlat_dir_o[i];
         status_o[i*CAB_FIELDS + CAB_F_OEN]  = cab_xlat_oe_n_o[i];
      end
      for (int j = 0; j < NUM_SHARED; j++) begin
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_REQA] = req_a_s[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_REQB] = req_b_s[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_XCVR] = shr_xcvr_dir_o[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_ADIR] = shr_a_dir_o[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_AOEN] = shr_a_oe_n_o[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_BDIR] = shr_b_dir_o[j];
         status_o[NUM_CABLES*CAB_FIELDS + j*SHR_FIELDS + SHR_F_BOEN] = shr_b_oe_n_o[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_ok_n_o <= 1'b1;
      else        run_ok_n_o <= ~both_ok;
   end
endmodule

// File: rtl/pda_checker.sv
module pda_checker #(
   parameter int NUM_CABLES = 3,
   parameter int NUM_SHARED = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_a_i,
   input logic                  b_fitted_n_i,
   input logic [NUM_CABLES-1:0] cab_xcvr_dir_o,
   input logic [NUM_CABLES-1:0] cab_xlat_oe_n_o,
   input logic [NUM_SHARED-1:0] shr_xcvr_dir_o,
   input logic [NUM_SHARED-1:0] shr_a_oe_n_o,
   input logic [NUM_SHARED-1:0] shr_b_dir_o,
   input logic [NUM_SHARED-1:0] shr_b_oe_n_o,
   input logic                  run_ok_n_o
);
   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_xcvr_dir_o & ~shr_a_oe_n_o & ~shr_b_oe_n_o) == '0); // R5

   AST_B_ABSENT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (b_fitted_n_i && $past(b_fitted_n_i) && $past(b_fitted_n_i, 2))
      |-> ((&shr_b_dir_o) && (&shr_b_oe_n_o))); // R4

   AST_SHR_SAFE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      run_ok_n_o |-> ((&shr_a_oe_n_o) && (&shr_b_oe_n_o))); // R6

   AST_SHR_SAFE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok_n_o && $past(run_ok_n_o)) |-> (&shr_xcvr_dir_o)); // R6

   AST_CAB_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cab_xcvr_dir_o ^ $past(cab_xcvr_dir_o)) &
       ~(cab_xlat_oe_n_o & $past(cab_xlat_oe_n_o))) == '0); // R7

   AST_SHR_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((shr_xcvr_dir_o ^ $past(shr_xcvr_dir_o)) &
       ~(shr_a_oe_n_o & $past(shr_a_oe_n_o))) == '0); // R7

   AST_RUN_OK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_ok_n_o |-> $past(cfg_a_i, 3)); // R8
endmodule

bind port_dir_arbiter pda_checker #(
   .NUM_CABLES (NUM_CABLES),
   .NUM_SHARED (NUM_SHARED)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_a_i         (cfg_a_i),
   .b_fitted_n_i    (b_fitted_n_i),
   .cab_xcvr_dir_o  (cab_xcvr_dir_o),
   .cab_xlat_oe_n_o (cab_xlat_oe_n_o),
   .shr_xcvr_dir_o  (shr_xcvr_dir_o),
   .shr_a_oe_n_o    (shr_a_oe_n_o),
   .shr_b_dir_o     (shr_b_dir_o),
   .shr_b_oe_n_o    (shr_b_oe_n_o),
   .run_ok_n_o      (run_ok_n_o)
);

// File: tb/port_dir_arbiter_tb.sv
module port_dir_arbiter_tb;
   localparam int NC = 3;
   localparam int NS = 2;
   localparam int SW = 4 * NC + 7 * NS;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, cfg_a, cfg_b, fit_n;
   logic [NC-1:0] cab_req;
   logic [NS-1:0] req_a, req_b;
   logic [NC-1:0] cab_xcvr, cab_xdir, cab_oen;
   logic [NS-1:0] shr_xcvr, a_dir, a_oen, b_dir, b_oen;
   logic [SW-1:0] status;
   logic          run_ok_n;

   port_dir_arbiter #(.NUM_CABLES(NC), .NUM_SHARED(NS), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .b_fitted_n_i(fit_n),
      .cab_req_in_i(cab_req), .shr_req_in_a_i(req_a), .shr_req_in_b_i(req_b),
      .cab_xcvr_dir_o(cab_xcvr), .cab_xlat_dir_o(cab_xdir), .cab_xlat_oe_n_o(cab_oen),
      .shr_xcvr_dir_o(shr_xcvr), .shr_a_dir_o(a_dir), .shr_a_oe_n_o(a_oen),
      .shr_b_dir_o(b_dir), .shr_b_oe_n_o(b_oen), .status_o(status), .run_ok_n_o(run_ok_n)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected settled values
   logic [NC-1:0] e_cx, e_cd, e_co;
   logic [NS-1:0] e_sx, e_ad, e_ao, e_bd, e_bo;
   logic [SW-1:0] e_st;
   logic          e_ok_n;

   task automatic model();
      logic ok, ao, bo, d;
      ok = cfg_a & (fit_n | cfg_b);
      e_ok_n = ~ok;
      for (int i = 0; i < NC; i++) begin
         e_cx[i] = cfg_a ? ~cab_req[i] : 1'b1;
         e_cd[i] = e_cx[i];
         e_co[i] = ~cfg_a;
      end
      for (int j = 0; j < NS; j++) begin
         ao = ~req_a[j];
         bo = ~fit_n & ~req_b[j];
         d  = ao | bo;
         if (!ok) begin
            e_sx[j] = 1; e_ad[j] = 1; e_ao[j] = 1; e_bd[j] = 1; e_bo[j] = 1;
         end else begin
            e_sx[j] = d;
            e_ad[j] = d;
            e_ao[j] = d ? ~ao : 1'b0;
            e_bd[j] = fit_n ? 1'b1 : d;
            e_bo[j] = fit_n ? 1'b1 : (d ? ~(bo & ~ao) : 1'b0);
         end
      end
      e_st = '0;
      for (int i = 0; i < NC; i++)
         e_st[4*i +: 4] = {e_co[i], e_cd[i], e_cx[i], cab_req[i]};
      for (int j = 0; j < NS; j++)
         e_st[4*NC + 7*j +: 7] = {e_bo[j], e_bd[j], e_ao[j], e_ad[j], e_sx[j], req_b[j], req_a[j]};
   endtask

   task automatic settle_check(input string what);
      repeat (8) @(negedge clk);
      model();
      chk({what, " R1 R2 cable dir"}, 64'(cab_xcvr), 64'(e_cx));
      chk({what, " R1 R2 cable oe_n"}, 64'(cab_oen), 64'(e_co));
      chk({what, " R3 cable dir match"}, 64'(cab_xdir), 64'(cab_xcvr));
      chk({what, " R5 R6 R11 shared dir"}, 64'(shr_xcvr), 64'(e_sx));
      chk({what, " R5 R11 A set"}, 64'({a_dir, a_oen}), 64'({e_ad, e_ao}));
      chk({what, " R4 R5 B set"}, 64'({b_dir, b_oen}), 64'({e_bd, e_bo}));
      chk({what, " R3 shared A dir match"}, 64'(a_dir), 64'(shr_xcvr));
      if (!fit_n) chk({what, " R3 shared B dir match"}, 64'(b_dir), 64'(shr_xcvr));
      chk({what, " R9 status"}, 64'(status), 64'(e_st));
      chk({what, " R8 run_ok_n"}, 64'(run_ok_n), 64'(e_ok_n));
   endtask

   task automatic print_summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         print_summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 0; cfg_a = 0; cfg_b = 0; fit_n = 1;
      cab_req = '1; req_a = '1; req_b = '1;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 reset cable", 64'({cab_xcvr, cab_xdir, cab_oen}), 64'({3*NC{1'b1}}));
      chk("R2 reset shared", 64'({shr_xcvr, a_dir, a_oen, b_dir, b_oen}), 64'({5*NS{1'b1}}));
      chk("R2 reset run_ok_n", 64'(run_ok_n), 64'(1));
      rst_n = 1;
      settle_check("unconfigured");

      // R8: exact edge of run_ok_n with B absent
      cfg_a = 1;
      @(negedge clk); chk("R8 run_ok edge1", 64'(run_ok_n), 64'(1));
      @(negedge clk); chk("R8 run_ok edge2", 64'(run_ok_n), 64'(1));
      @(negedge clk); chk("R8 run_ok edge3", 64'(run_ok_n), 64'(0));
      settle_check("A only");

      // R7 R10: cable 0 from input to output, edge by edge
      cab_req[0] = 0;
      @(negedge clk); chk("R10 e1", 64'({cab_xcvr[0], cab_oen[0]}), 64'(2'b00));
      @(negedge clk); chk("R10 e2", 64'({cab_xcvr[0], cab_oen[0]}), 64'(2'b00));
      @(negedge clk); chk("R7 e3 oe off", 64'({cab_xcvr[0], cab_oen[0]}), 64'(2'b01));
      @(negedge clk); chk("R7 e4 flip", 64'({cab_xcvr[0], cab_oen[0]}), 64'(2'b11));
      @(negedge clk); chk("R7 e5 oe on", 64'({cab_xcvr[0], cab_oen[0]}), 64'(2'b10));

      // R4: absent B asks for output, must be ignored
      req_b = '0; req_a = '1;
      settle_check("R4 absent B ignored");

      // R6: B fitted but not configured
      fit_n = 0; cfg_b = 0;
      settle_check("R6 B unconfigured");

      // R5: contention on conn0, B alone on conn1
      cfg_b = 1; req_a = 2'b10; req_b = 2'b00;
      settle_check("R5 A wins and B alone");

      // R11: both input
      req_a = '1; req_b = '1;
      settle_check("R11 both input");

      // R5 handover from B to A without direction change
      req_a = 2'b11; req_b = 2'b00;
      settle_check("R5 B drives");
      req_a = 2'b00;
      settle_check("R5 A takes over");

      // constrained random
      for (int it = 0; it < 60; it++) begin
         cfg_a   = ($urandom % 4) != 0;
         cfg_b   = ($urandom % 4) != 0;
         fit_n   = ($urandom % 4) == 0;
         cab_req = NC'($urandom);
         req_a   = NS'($urandom);
         req_b   = NS'($urandom);
         settle_check("random");
      end

      done = 1;
      print_summary();
      $finish;
   end
endmodule